// File: doc/BRIEF.md
# Four-Channel Compare Waveform Generator

This block is the output stage of a timer. Each cycle it is given a counter sample, the count direction and one compare value per channel, and it drives one registered waveform bit per channel. A three-bit mode word picks one of eight rules for setting and clearing the outputs. The rules are two toggling frequency modes, a single-slope PWM, a paired dual-compare PWM and four dual-slope (centre-aligned) PWM variants. A polarity bit per channel flips the sense of the PWM levels. The counter, fault logic, dead time and the register bus stay outside the block.

The counter samples form a stream qualified by `tick`. The stage takes a sample in every cycle and applies no back-pressure, so it has no ready signal. A cycle with `tick` low carries no sample. The mode word is protected: it loads only while the timer is disabled. The polarity bits can be written at any time. In the PWM modes the output levels are given relative to `dir` (0 = counting up, 1 = counting down), so the same setting gives mirrored edges on the two slopes.

Top module: `cmpwave_gen`

## Requirements
- R1: After reset all `wave_o` bits are 0, the mode is normal frequency (code 0) and all polarity bits are 0.
- R2: In mode code 0, an active sample (`tmr_en`=1, `tick`=1) with `count`==compare n toggles `wave_o[n]`; polarity has no effect.
- R3: In mode code 1, an active sample with `count`==compare 0 toggles every channel; polarity has no effect.
- R4: In mode code 2, an active sample with `count`==compare n drives `wave_o[n]` to `dir` XOR pol[n]. Otherwise, at a period boundary (`count`==`top_val` with `dir`=0, or `count`==0 with `dir`=1), the pulse state clears and the output goes to NOT `dir` XOR pol[n]. Otherwise the output follows the held pulse state with the current `dir`. A match wins over a boundary.
- R5: In mode code 3, each channel n below NCH/2 has a pulse state. The state sets on compare n, clears on compare n+NCH/2 and clears at the R4 boundary, in that priority. The levels follow R4. Channel n+NCH/2 uses the same pulse window with its own polarity bit.
- R6: In mode codes 4 to 7, an active sample with `count`==compare n drives `wave_o[n]` to NOT `dir` XOR pol[n]; with no match and no R7 boundary the output holds.
- R7: In the dual-slope modes, a sample at a boundary with no match drives `wave_o[n]` to pol[n]. The boundary is `count`==0 for code 5, `count`==`top_val` for code 7 and either of these for code 6. Code 4 has no boundary.
- R8: A mode write (`mode_we`) loads `mode_wd` and clears every pulse state only while `tmr_en`=0. While `tmr_en`=1 the write is ignored.
- R9: A polarity write (`pol_we`, bit n of `pol_wd` is channel n) is accepted in any state and applies from the next sample.
- R10: In a cycle with `tmr_en`=0 or `tick`=0, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_en | input | 1 | Timer enabled; locks the mode word |
| tick | input | 1 | Counter sample valid this cycle |
| dir | input | 1 | Count direction, 0 = up, 1 = down |
| count | input | CW | Counter sample |
| top_val | input | CW | Counter top value |
| cmp_flat | input | NCH*CW | Compare values, channel n at bits n*CW upward |
| mode_we | input | 1 | Mode write strobe |
| mode_wd | input | 3 | Mode code to write |
| pol_we | input | 1 | Polarity write strobe |
| pol_wd | input | NCH | Polarity bits, bit n for channel n |
| wave_o | output | NCH | Registered waveform outputs |

## Verification
A sample that is active at clock edge k shows on `wave_o` directly after edge k, so each output is due one cycle after its stimulus. A mode or polarity write made at edge k governs the samples taken from edge k+1 onward. The bench drives every input one time step after a rising edge. It updates its model with the values the configuration registers held before that edge, and then applies any write made in the same cycle. It compares the outputs one time step after the next rising edge. The bench runs every mode against several polarity patterns and compare layouts, and it inserts idle samples, locked mode writes and polarity writes in the middle of a run.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;
  typedef enum logic [2:0] {
    WM_NFRQ    = 3'd0,
    WM_MFRQ    = 3'd1,
    WM_NPWM    = 3'd2,
    WM_DPWM    = 3'd3,
    WM_DS_CRIT = 3'd4,
    WM_DS_BOT  = 3'd5,
    WM_DS_BOTH = 3'd6,
    WM_DS_TOP  = 3'd7
  } wmode_e;

  function automatic logic is_dual_slope(input wmode_e m);
    return m[2];
  endfunction
endpackage

// File: rtl/cmpwave_cfg.sv
module cmpwave_cfg
  import cmpwave_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tmr_en,
  input  logic           mode_we,
  input  logic [2:0]     mode_wd,
  input  logic           pol_we,
  input  logic [NCH-1:0] pol_wd,
  output wmode_e         mode_q,
  output logic           mode_load,
  output logic [NCH-1:0] pol_q
);
  assign mode_load = mode_we && !tmr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WM_NFRQ;
      pol_q  <= '0;
    end else begin
      if (mode_load) mode_q <= wmode_e'(mode_wd);
      if (pol_we)    pol_q  <= pol_wd;
    end
  end

  assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en |=> $stable(mode_q));

  assert_pol_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pol_we |=> pol_q == $past(pol_wd));
endmodule

// File: rtl/cmpwave_events.sv
module cmpwave_events
  import cmpwave_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic [CW-1:0]     count,
  input  logic [CW-1:0]     top_val,
  input  logic [NCH*CW-1:0] cmp_flat,
  input  wmode_e            mode,
  output logic [NCH-1:0]    set_m,
  output logic [NCH-1:0]    clr_m,
  output logic              top0_m,
  output logic              top_hit,
  output logic              bot_hit
);
  localparam int HALF = NCH / 2;

  logic [NCH-1:0] eq;
  logic           paired;

  assign paired  = (mode == WM_DPWM);
  assign top0_m  = eq[0];
  assign top_hit = (count == top_val);
  assign bot_hit = (count == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_eq
    assign eq[g] = (count == cmp_flat[g*CW +: CW]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_route
    if (g < HALF) begin : g_lo
      assign set_m[g] = eq[g];
      assign clr_m[g] = paired && eq[g+HALF];
    end else begin : g_hi
      assign set_m[g] = paired ? eq[g-HALF] : eq[g];
      assign clr_m[g] = paired && eq[g];
    end
  end
endmodule

// File: rtl/cmpwave_chan.sv
module cmpwave_chan
  import cmpwave_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   act,
  input  logic   mode_load,
  input  wmode_e mode,
  input  logic   pol,
  input  logic   dir,
  input  logic   set_m,
  input  logic   clr_m,
  input  logic   top0_m,
  input  logic   top_hit,
  input  logic   bot_hit,
  output logic   wave_q
);
  logic phase_q, phase_d, wave_d, ss_bnd, ds_bnd;

  always_comb begin
    ss_bnd = dir ? bot_hit : top_hit;
    case (mode)
      WM_DS_BOT:  ds_bnd = bot_hit;
      WM_DS_BOTH: ds_bnd = bot_hit | top_hit;
      WM_DS_TOP:  ds_bnd = top_hit;
      default:    ds_bnd = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    wave_d  = wave_q;
    if (act) begin
      case (mode)
        WM_NFRQ: if (set_m)  wave_d = ~wave_q;
        WM_MFRQ: if (top0_m) wave_d = ~wave_q;
        WM_NPWM: begin
          if (set_m)       phase_d = 1'b1;
          else if (ss_bnd) phase_d = 1'b0;
          wave_d = ~(dir ^ phase_d) ^ pol;
        end
        WM_DPWM: begin
          if (set_m)       phase_d = 1'b1;
          else if (clr_m)  phase_d = 1'b0;
          else if (ss_bnd) phase_d = 1'b0;
          wave_d = ~(dir ^ phase_d) ^ pol;
        end
        default: begin
          if (set_m)       wave_d = ~dir ^ pol;
          else if (ds_bnd) wave_d = pol;
        end
      endcase
    end
    if (mode_load) phase_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wave_q  <= wave_d;
    end
  end

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> $stable(wave_q));

  assert_freq_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act && mode == WM_NFRQ && set_m |=> wave_q != $past(wave_q));

  assert_npwm_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act && mode == WM_NPWM && set_m |=> wave_q == ($past(dir) ^ $past(pol)));

  assert_ds_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act && is_dual_slope(mode) && set_m |=> wave_q == (!$past(dir) ^ $past(pol)));
endmodule

// File: rtl/cmpwave_gen.sv
module cmpwave_gen
  import cmpwave_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en,
  input  logic              tick,
  input  logic              dir,
  input  logic [CW-1:0]     count,
  input  logic [CW-1:0]     top_val,
  input  logic [NCH*CW-1:0] cmp_flat,
  input  logic              mode_we,
  input  logic [2:0]        mode_wd,
  input  logic              pol_we,
  input  logic [NCH-1:0]    pol_wd,
  output logic [NCH-1:0]    wave_o
);
  localparam int HALF = NCH / 2;

  wmode_e         mode_q;
  logic           mode_load;
  logic [NCH-1:0] pol_q, set_m, clr_m;
  logic           top0_m, top_hit, bot_hit, act;

  assign act = tmr_en && tick;

  cmpwave_cfg #(.NCH(NCH)) cfg_i (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en),
    .mode_we(mode_we), .mode_wd(mode_wd),
    .pol_we(pol_we), .pol_wd(pol_wd),
    .mode_q(mode_q), .mode_load(mode_load), .pol_q(pol_q)
  );

  cmpwave_events #(.NCH(NCH), .CW(CW)) ev_i (
    .count(count), .top_val(top_val), .cmp_flat(cmp_flat), .mode(mode_q),
    .set_m(set_m), .clr_m(clr_m), .top0_m(top0_m),
    .top_hit(top_hit), .bot_hit(bot_hit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmpwave_chan ch_i (
      .clk(clk), .rst_n(rst_n), .act(act), .mode_load(mode_load),
      .mode(mode_q), .pol(pol_q[g]), .dir(dir),
      .set_m(set_m[g]), .clr_m(clr_m[g]), .top0_m(top0_m),
      .top_hit(top_hit), .bot_hit(bot_hit), .wave_q(wave_o[g])
    );
  end

  for (genvar p = 0; p < HALF; p++) begin : g_pair_chk
    assert_pair_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act && mode_q == WM_DPWM |=>
        wave_o[p+HALF] == (wave_o[p] ^ $past(pol_q[p] ^ pol_q[p+HALF])));
  end

  assert_mfrq_common_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act && mode_q == WM_MFRQ && top0_m |=> wave_o == ~$past(wave_o));
endmodule

// File: tb/cmpwave_gen_tb_top.sv
`timescale 1ns/1ps
module cmpwave_gen_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int TOP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0, tick = 1'b0, dir = 1'b0;
  logic [CW-1:0] count = '0, top_val = CW'(TOP);
  logic [NCH*CW-1:0] cmp_flat = '0;
  logic mode_we = 1'b0, pol_we = 1'b0;
  logic [2:0] mode_wd = '0;
  logic [NCH-1:0] pol_wd = '0;
  logic [NCH-1:0] wave_o;

  always #5 clk = ~clk;

  cmpwave_gen #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tick(tick), .dir(dir),
    .count(count), .top_val(top_val), .cmp_flat(cmp_flat),
    .mode_we(mode_we), .mode_wd(mode_wd), .pol_we(pol_we), .pol_wd(pol_wd),
    .wave_o(wave_o)
  );

  int vectors = 0, miscompares = 0;
  string tag = "R1";
  int mode_m = 0;
  logic [NCH-1:0] pol_m = '0, ph_m = '0, out_m = '0;
  int cc [NCH];

  function automatic bit eqc(int idx, int c);
    return c == cc[idx];
  endfunction

  task automatic model(bit tk, int c, bit d);
    bit act = tmr_en && tk;
    bit ssb = d ? (c == 0) : (c == TOP);
    bit dsb;
    case (mode_m)
      5: dsb = (c == 0);
      6: dsb = (c == 0) || (c == TOP);
      7: dsb = (c == TOP);
      default: dsb = 1'b0;
    endcase
    if (act) begin
      for (int n = 0; n < NCH; n++) begin
        bit s, k;
        if (mode_m == 3) begin
          s = (n < NCH/2) ? eqc(n, c) : eqc(n - NCH/2, c);
          k = (n < NCH/2) ? eqc(n + NCH/2, c) : eqc(n, c);
        end else begin
          s = eqc(n, c);
          k = 1'b0;
        end
        case (mode_m)
          0: if (s) out_m[n] = ~out_m[n];
          1: if (eqc(0, c)) out_m[n] = ~out_m[n];
          2, 3: begin
            if (s) ph_m[n] = 1'b1;
            else if (k || ssb) ph_m[n] = 1'b0;
            out_m[n] = ~(d ^ ph_m[n]) ^ pol_m[n];
          end
          default: begin
            if (s) out_m[n] = ~d ^ pol_m[n];
            else if (dsb) out_m[n] = pol_m[n];
          end
        endcase
      end
    end
    if (mode_we && !tmr_en) begin
      mode_m = int'(mode_wd);
      ph_m = '0;
    end
    if (pol_we) pol_m = pol_wd;
  endtask

  task automatic step(bit tk, int c, bit d);
    string t;
    tick = tk;
    count = CW'(c);
    dir = d;
    model(tk, c, d);
    @(posedge clk);
    #1;
    mode_we = 1'b0;
    pol_we = 1'b0;
    t = tk ? tag : "R10";
    vectors++;
    if (wave_o !== out_m) begin
      miscompares++;
      $display("FAIL %s mode=%0d cnt=%0d dir=%0d actual=%b expected=%b",
               t, mode_m, c, d, wave_o, out_m);
    end
  endtask

  task automatic set_cc(int p);
    for (int n = 0; n < NCH; n++) begin
      cc[n] = (3 * n + 2 + p) % TOP;
      cmp_flat[n*CW +: CW] = CW'(cc[n]);
    end
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [NCH-1:0] pols [4];
    pols[0] = 4'h0; pols[1] = 4'h5; pols[2] = 4'hA; pols[3] = 4'hF;
    set_cc(0);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    vectors++;
    if (wave_o !== '0) begin
      miscompares++;
      $display("FAIL R1 reset actual=%b expected=0000", wave_o);
    end
    // R1: reset mode is normal frequency with polarity 0
    tmr_en = 1'b1;
    tag = "R1";
    for (int c = 0; c <= TOP; c++) step(1'b1, c, 1'b0);

    for (int m = 0; m < 8; m++) begin
      for (int pi = 0; pi < 4; pi++) begin
        tmr_en = 1'b0;
        set_cc(pi + m);
        mode_we = 1'b1; mode_wd = 3'(m);
        tag = "R8";
        step(1'b0, 0, 1'b0);
        pol_we = 1'b1; pol_wd = pols[pi];
        tag = "R9";
        step(1'b0, 0, 1'b0);
        tmr_en = 1'b1;
        case (m)
          0: tag = "R2";
          1: tag = "R3";
          2: tag = "R4";
          3: tag = "R5";
          4: tag = "R6";
          default: tag = "R7";
        endcase
        for (int r = 0; r < 2; r++) begin
          for (int c = 0; c <= TOP; c++) begin
            if (c == 5 && r == 0) begin
              mode_we = 1'b1; mode_wd = 3'((m + 3) % 8);
            end
            if (c == 8 && r == 1) begin
              pol_we = 1'b1; pol_wd = ~pol_m;
            end
            if ((c % 7) == 3) step(1'b0, c, 1'b0);
            step(1'b1, c, 1'b0);
          end
          if (m >= 4) begin
            for (int c = TOP - 1; c >= 1; c--) step(1'b1, c, 1'b1);
          end else if (m == 2 || m == 3) begin
            for (int c = TOP; c >= 0; c--) step(1'b1, c, 1'b1);
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule